// File: doc/BRIEF.md
# Line-Counted Vertical Sync Qualifier

The block takes a raw vertical sync level that picks up crosstalk from the horizontal deflection and turns it into a clean vertical sync event for the rest of the display timing logic. The raw vertical level and the horizontal sync pulse train both arrive asynchronously. Each one passes through a two-flop synchroniser, and rising edges are then detected on the synchronised copies.

Time is measured in display lines, not in clock cycles. Each synchronised rising edge of the horizontal input counts as one line. While the synchronised vertical level is low, a saturating counter tallies lines. Any high level on the vertical input clears that counter at once. A rising edge of the vertical level is taken as genuine only when the counter has gone past the minimum line count `LINES_MIN`. An accepted edge produces a one-clock pulse and sets a level flag. A rejected edge produces nothing.

The block has no data stream, so it has no valid/ready handshake and applies no back-pressure. All pins are plain control signals that are sampled or updated on every clock.

Top module: `vsync_qualifier`

## Requirements
- R1: After an asynchronous active-low reset, `vq_pulse_o` and `vq_level_o` are 0 and the line count is 0. A complete qualifying low period must follow reset before any edge is accepted.
- R2: Both asynchronous inputs pass through two synchronising flops. For an accepted edge, `vq_pulse_o` is high in the third clock cycle after the raw vertical input rises, and not before.
- R3: The line count advances by one for each synchronised rising edge of `hsync_i` seen while the synchronised vertical level is low. It does not change otherwise.
- R4: Whenever the synchronised vertical level is high, the line count is cleared on the next clock. This includes a brief high glitch in the middle of a low period.
- R5: A synchronised vertical rising edge is accepted only when the line count is strictly greater than `LINES_MIN` (default 8). With the default, 9 lines are accepted and 8 lines are rejected.
- R6: A rejected rising edge leaves `vq_pulse_o` at 0 and `vq_level_o` at 0.
- R7: Each accepted edge gives a `vq_pulse_o` pulse that lasts exactly one clock cycle.
- R8: `vq_level_o` rises together with the accepted pulse and stays high while the synchronised vertical level is high. It returns to 0 in the third clock cycle after the raw vertical input falls.
- R9: The line count saturates at `LINES_MIN`+1, so an arbitrarily long low period is still accepted.
- R10: After an accepted edge, the next rising edge needs a new qualifying low period of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vraw_i | input | 1 | Raw vertical sync level, asynchronous, active high |
| hsync_i | input | 1 | Horizontal sync pulse train, asynchronous; each rising edge counts as one line |
| vq_pulse_o | output | 1 | One-clock pulse on each accepted vertical rising edge |
| vq_level_o | output | 1 | Qualified vertical level: high from the accepted edge until the input falls |

## Verification
The embedded assertions check several rules on every cycle:
- the counter is cleared while the vertical level is high;
- the counter stays at or below its saturation value and holds when no line tick arrives;
- a pulse never lasts beyond one cycle and always coincides with the level flag;
- every pulse comes from a qualified edge, and an unqualified edge is never followed by a pulse.

Only the bench scenarios can show the end-to-end behaviour:
- the exact three-cycle latency through the synchronisers;
- the accept/reject boundary between 8 and 9 lines;
- the effect of a mid-period glitch;
- the need for a fresh qualifying period after reset and after each accepted edge.

// File: rtl/vq_pkg.sv
package vq_pkg;
  // bit positions of the two asynchronous inputs inside the shared synchroniser
  localparam int unsigned IDX_V = 0;
  localparam int unsigned IDX_H = 1;
  localparam int unsigned N_IN  = 2;

  typedef logic [N_IN-1:0] vq_in_t;
endpackage

// File: rtl/vq_sync.sv
module vq_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/vq_edge.sv
module vq_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= d_i;
  end

  assign rise_o = d_i & ~prev;
endmodule

// File: rtl/vq_line_cnt.sv
module vq_line_cnt #(
  parameter int unsigned LINES_MIN = 8,
  localparam int unsigned SAT      = LINES_MIN + 1,
  localparam int unsigned CW       = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_high_i,
  input  logic          line_tick_i,
  output logic          qualified_o,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cnt;
  logic          sat;

  assign sat = (cnt == CW'(SAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (v_high_i)           cnt <= '0;
    else if (line_tick_i && !sat) cnt <= cnt + 1'b1;
  end

  assign qualified_o = sat;
  assign count_o     = cnt;

  // R4: a high vertical level empties the counter on the next clock
  p_clear_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    v_high_i |=> (cnt == '0));

  // R9: the counter never goes beyond its saturation value
  p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(SAT));

  // R3: without a line tick during a low period the counter holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_high_i && !line_tick_i) |=> $stable(cnt));
endmodule

// File: rtl/vsync_qualifier.sv
module vsync_qualifier #(
  parameter int unsigned LINES_MIN   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = $clog2(LINES_MIN + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vraw_i,
  input  logic hsync_i,
  output logic vq_pulse_o,
  output logic vq_level_o
);
  import vq_pkg::*;

  vq_in_t        raw_in;
  vq_in_t        syn;
  vq_in_t        rise;
  logic          qualified;
  logic [CW-1:0] line_count;
  logic          accept;

  assign raw_in[IDX_V] = vraw_i;
  assign raw_in[IDX_H] = hsync_i;

  vq_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn)
  );

  vq_edge #(.W(N_IN)) u_edge (
    .clk(clk), .rst_n(rst_n), .d_i(syn), .rise_o(rise)
  );

  vq_line_cnt #(.LINES_MIN(LINES_MIN)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .v_high_i(syn[IDX_V]), .line_tick_i(rise[IDX_H]),
    .qualified_o(qualified), .count_o(line_count)
  );

  assign accept = rise[IDX_V] && qualified;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq_pulse_o <= 1'b0;
      vq_level_o <= 1'b0;
    end else begin
      vq_pulse_o <= accept;
      if (accept)              vq_level_o <= 1'b1;
      else if (!syn[IDX_V])    vq_level_o <= 1'b0;
    end
  end

  // R7: a pulse is never longer than one clock
  p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vq_pulse_o |=> !vq_pulse_o);

  // R6: an edge seen before the count qualifies is not followed by a pulse
  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[IDX_V] && !qualified) |=> !vq_pulse_o);

  // R5: each pulse comes from an edge that met the line threshold
  p_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vq_pulse_o |-> $past(rise[IDX_V] && (line_count > CW'(LINES_MIN))));

  // R8: the level flag is up whenever a pulse is out
  p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vq_pulse_o |-> vq_level_o);
endmodule

// File: tb/vsync_qualifier_tb.sv
module vsync_qualifier_tb;
  localparam int LM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vraw = 1'b0;
  logic hs = 1'b0;
  logic vq_pulse, vq_level;
  int   n_run = 0;
  int   n_fail = 0;
  int   cyc = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  vsync_qualifier #(.LINES_MIN(LM)) u_dut (
    .clk(clk), .rst_n(rst_n), .vraw_i(vraw), .hsync_i(hs),
    .vq_pulse_o(vq_pulse), .vq_level_o(vq_level)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hline(input int n);
    for (int i = 0; i < n; i++) begin
      hs = 1'b1; waitn(2);
      hs = 1'b0; waitn(2);
    end
  endtask

  // raise vraw from low; check latency (R2), acceptance and pulse width
  task automatic rise_and_check(input string req, input logic exp_acc);
    vraw = 1'b1;
    waitn(2);
    chk("R2 no early pulse", vq_pulse, 1'b0);
    waitn(1);
    chk(req, vq_pulse, exp_acc);
    chk(exp_acc ? "R8 level set" : "R6 level stays low", vq_level, exp_acc);
    waitn(1);
    chk("R7 pulse one cycle", vq_pulse, 1'b0);
    hline(3);  // lines during high must not count (R3/R4)
    chk(exp_acc ? "R8 level held" : "R6 level still low", vq_level, exp_acc);
    vraw = 1'b0;
    waitn(2);
    chk("R8 level before fall latency", vq_level, exp_acc);
    waitn(1);
    chk("R8 level cleared", vq_level, 1'b0);
    waitn(2);
  endtask

  initial begin
    waitn(3);
    chk("R1 pulse reset", vq_pulse, 1'b0);
    chk("R1 level reset", vq_level, 1'b0);
    rst_n = 1'b1;
    waitn(3);
    // R1: straight after reset, too few lines must be rejected
    hline(LM);
    rise_and_check("R1 R5 post-reset short period", 1'b0);
    // R5 R6: sweep of line counts around the threshold
    for (int n = 0; n <= LM + 4; n++) begin
      hline(n);
      rise_and_check($sformatf("R5 sweep n=%0d", n), (n > LM));
    end
    // R9: very long low period saturates and still qualifies
    hline(4 * LM);
    rise_and_check("R9 saturated count", 1'b1);
    // R4: glitch in the middle restarts the count
    hline(LM - 2);
    vraw = 1'b1; waitn(3); vraw = 1'b0; waitn(3);
    hline(LM - 2);
    waitn(1);
    vraw = 1'b1; waitn(3);
    chk("R4 glitch restarts count", vq_pulse, 1'b0);
    vraw = 1'b0; waitn(4);
    // R10: after an accepted edge a new full period is needed
    hline(LM + 1);
    rise_and_check("R10 first edge accepted", 1'b1);
    hline(LM);
    rise_and_check("R10 second edge needs fresh period", 1'b0);
    // R3: idle time without lines does not count
    waitn(200);
    rise_and_check("R3 clocks are not lines", 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule